// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and Character Compare

This block turns an asynchronous serial line into characters. A one-cycle sample strobe, running at sixteen times the bit rate, paces all line sampling. The receiver first confirms the start bit at its midpoint, then reads 5 to 8 data bits with the least significant bit first. An optional parity bit follows, and then the stop bit. Each finished character goes into a four-entry show-ahead FIFO together with parity, framing, overrun and break flags.

A break is a character time of all zeros that ends in a low stop bit. It is stored in the FIFO only once. Its first detection raises a start pulse, and a second pulse marks the return of the line to high. Each received non-break character can also be compared with a programmed byte, and a match raises a one-cycle event.

Top module: `uart_rx_brk`

## Requirements
- R1: The first low sample seen while idle starts a candidate start bit. If the line is high at the 8th sample strobe, counting that first low sample as the 1st, the candidate is discarded and no character is stored.
- R2: The `cfg_len` field selects 5 to 8 data bits, with 0 meaning 5 and 3 meaning 8. Bits are taken least significant first and sampled every 16 strobes after the start midpoint. Unused upper bits of `rd_data` read as zero.
- R3: `cfg_par` sets the parity mode: 0 none, 1 even, 2 odd, 3 fixed. In fixed mode the parity bit must equal `cfg_par_val`. A mismatch sets `rd_perr` on that character.
- R4: A low stop bit on a character that is not a break stores the character with `rd_ferr`=1. The search for the next start bit resumes 8 strobes after the stop sample, so the rest of the low stop bit does not create a spurious character.
- R5: A break is all-zero data, a zero parity bit if parity is enabled, and a low stop bit. It stores exactly one entry with data 0, `rd_brk`=1 and `rd_ferr`=1, and pulses `brk_start` for one cycle. Nothing more is stored until the line is high again.
- R6: After a break, `brk_end` pulses for one cycle at the first strobe that sees the line high. It never pulses without a preceding `brk_start`.
- R7: The FIFO holds four entries. The head entry is shown while `rd_valid` is 1, and `pop` removes it. A pop while the FIFO is empty has no effect.
- R8: A character that completes while the FIFO is full and `pop` is low is dropped. The next character that is stored carries `rd_ovr`=1.
- R9: A character that completes in the same cycle as a pop of a full FIFO is stored. No overrun is flagged.
- R10: With `cmp_en`=1, `cmp_match` pulses for one cycle, one clock after a non-break character equal to `cmp_val` completes. It never pulses for a break.
- R11: After reset the FIFO is empty and `brk_start`, `brk_end` and `cmp_match` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sample strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 fixed |
| cfg_par_val | input | 1 | Expected parity bit in fixed mode |
| cmp_en | input | 1 | Enables the compare event |
| cmp_val | input | 8 | Compare byte |
| pop | input | 1 | Removes the head FIFO entry |
| rd_valid | output | 1 | FIFO not empty |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_ovr | output | 1 | Head entry follows a dropped character |
| rd_brk | output | 1 | Head entry is a break |
| brk_start | output | 1 | One-cycle pulse at break detection |
| brk_end | output | 1 | One-cycle pulse when the line returns high after a break |
| cmp_match | output | 1 | One-cycle compare match pulse |

## Verification
The pair of events that can share a cycle is a character completing and a pop of a full FIFO. The bench first measures, at the ports, how many clocks pass from a frame start to `rd_valid` rising on an empty FIFO. It then fills the FIFO and starts a fifth frame at the same strobe phase, raising `pop` for exactly the clock edge on which that character is written. The check passes if all four remaining entries are read back in order with `rd_ovr` clear, which a design that refuses writes when full would fail.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FIXED = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        FR_HUNT,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP,
        FR_SKIP,
        FR_BRK
    } fr_state_e;

    typedef struct packed {
        logic       brk;
        logic       ovr;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_word_t;

    // Parity check result for a received character
    function automatic logic parity_fault(input logic [7:0] d, input par_mode_e m,
                                          input logic fixv, input logic pbit);
        logic f;
        case (m)
            PAR_EVEN:  f = (^d) ^ pbit;
            PAR_ODD:   f = ~((^d) ^ pbit);
            PAR_FIXED: f = (pbit != fixv);
            default:   f = 1'b0;
        endcase
        return f;
    endfunction

    // Index of the final data bit for a length code
    function automatic logic [2:0] last_bit_idx(input logic [1:0] len);
        return 3'(len) + 3'd4;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx,
    input  logic [1:0] cfg_len,
    input  par_mode_e cfg_par,
    input  logic      cfg_par_val,
    output logic      word_vld,
    output rx_word_t  word,
    output logic      brk_start,
    output logic      brk_end
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);

    fr_state_e   state;
    logic [CW-1:0] cnt;
    logic [2:0]  bit_idx;
    logic [7:0]  shreg;
    logic        pbit;
    logic        perr_now;
    logic        has_par;
    logic [2:0]  last_idx;

    assign has_par  = (cfg_par != PAR_NONE);
    assign last_idx = last_bit_idx(cfg_len);
    assign perr_now = parity_fault(shreg, cfg_par, cfg_par_val, pbit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FR_HUNT;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            pbit      <= 1'b0;
            word_vld  <= 1'b0;
            word      <= '0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            word_vld  <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            if (tick) begin
                case (state)
                    FR_HUNT: begin
                        if (!rx) begin
                            state <= FR_START;
                            cnt   <= CW'(1);
                        end
                    end
                    FR_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt <= '0;
                            if (rx) begin
                                state <= FR_HUNT;
                            end else begin
                                state   <= FR_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                pbit    <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    FR_DATA: begin
                        if (cnt == LAST_TICK) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= rx;
                            if (bit_idx == last_idx) begin
                                state <= has_par ? FR_PAR : FR_STOP;
                            end else begin
                                bit_idx <= bit_idx + 3'd1;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    FR_PAR: begin
                        if (cnt == LAST_TICK) begin
                            cnt   <= '0;
                            pbit  <= rx;
                            state <= FR_STOP;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    FR_STOP: begin
                        if (cnt == LAST_TICK) begin
                            cnt       <= '0;
                            word_vld  <= 1'b1;
                            word.data <= shreg;
                            word.ovr  <= 1'b0;
                            if (rx) begin
                                word.brk  <= 1'b0;
                                word.ferr <= 1'b0;
                                word.perr <= perr_now;
                                state     <= FR_HUNT;
                            end else if (shreg == 8'h00 && !(has_par && pbit)) begin
                                word.brk  <= 1'b1;
                                word.ferr <= 1'b1;
                                word.perr <= 1'b0;
                                brk_start <= 1'b1;
                                state     <= FR_BRK;
                            end else begin
                                word.brk  <= 1'b0;
                                word.ferr <= 1'b1;
                                word.perr <= perr_now;
                                state     <= FR_SKIP;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    FR_SKIP: begin
                        if (cnt == HALF_LAST) begin
                            cnt   <= '0;
                            state <= FR_HUNT;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    FR_BRK: begin
                        if (rx) begin
                            brk_end <= 1'b1;
                            state   <= FR_HUNT;
                        end
                    end
                    default: state <= FR_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LVW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  rx_word_t       wr_word,
    input  logic           rd_en,
    output rx_word_t       rd_word,
    output logic           empty,
    output logic           full,
    output logic [LVW-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0]  PTR_LAST = PW'(DEPTH - 1);
    localparam logic [LVW-1:0] LVL_FULL = LVW'(DEPTH);

    rx_word_t      mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic          do_rd;
    logic          do_wr;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PW'(1);
    endfunction

    assign empty = (level == '0);
    assign full  = (level == LVL_FULL);
    assign do_rd = rd_en && !empty;
    assign do_wr = wr_en && (!full || do_rd);
    assign rd_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_rd) rd_ptr <= ptr_next(rd_ptr);
            if (do_wr) wr_ptr <= ptr_next(wr_ptr);
            if (do_wr && !do_rd)      level <= level + LVW'(1);
            else if (do_rd && !do_wr) level <= level - LVW'(1);
        end
    end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       samp_en,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_par_val,
    input  logic       cmp_en,
    input  logic [7:0] cmp_val,
    input  logic       pop,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_ovr,
    output logic       rd_brk,
    output logic       brk_start,
    output logic       brk_end,
    output logic       cmp_match
);
    localparam int LVW = $clog2(FIFO_DEPTH + 1);

    logic           rx_s;
    logic           fr_vld;
    rx_word_t       fr_word;
    rx_word_t       wr_word;
    rx_word_t       head;
    logic           fifo_empty;
    logic           fifo_full;
    logic [LVW-1:0] fifo_level;
    logic           accept;
    logic           ovr_pend;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .tick        (samp_en),
        .rx          (rx_s),
        .cfg_len     (cfg_len),
        .cfg_par     (par_mode_e'(cfg_par)),
        .cfg_par_val (cfg_par_val),
        .word_vld    (fr_vld),
        .word        (fr_word),
        .brk_start   (brk_start),
        .brk_end     (brk_end)
    );

    // A full FIFO still takes a word when the head leaves in the same cycle
    assign accept = fr_vld && (!fifo_full || pop);

    always_comb begin
        wr_word     = fr_word;
        wr_word.ovr = ovr_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_pend <= 1'b0;
        end else if (fr_vld) begin
            ovr_pend <= !accept;
        end
    end

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .LVW(LVW)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_word (wr_word),
        .rd_en   (pop),
        .rd_word (head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .level   (fifo_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_match <= 1'b0;
        end else begin
            cmp_match <= fr_vld && !fr_word.brk && cmp_en && (fr_word.data == cmp_val);
        end
    end

    assign rd_valid = !fifo_empty;
    assign rd_data  = head.data;
    assign rd_perr  = head.perr;
    assign rd_ferr  = head.ferr;
    assign rd_ovr   = head.ovr;
    assign rd_brk   = head.brk;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int DEPTH = 4,
    parameter int LVW   = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           rd_valid,
    input logic           brk_start,
    input logic           brk_end,
    input logic           cmp_match,
    input logic           cmp_en,
    input logic           fr_vld,
    input logic [LVW-1:0] fifo_level
);
    logic in_brk;

    always_ff @(posedge clk) begin
        if (rst)            in_brk <= 1'b0;
        else if (brk_start) in_brk <= 1'b1;
        else if (brk_end)   in_brk <= 1'b0;
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVW'(DEPTH));

    p_brk_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        brk_start |=> !brk_start);

    p_brk_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        in_brk |-> !fr_vld);

    p_brk_end_order_r6: assert property (@(posedge clk) disable iff (rst)
        brk_end |-> in_brk);

    p_match_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        cmp_match |=> !cmp_match);

    p_match_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        cmp_match |-> $past(cmp_en));

    p_reset_empty_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !rd_valid);
endmodule

bind uart_rx_brk uart_rx_chk #(.DEPTH(FIFO_DEPTH), .LVW(LVW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_valid   (rd_valid),
    .brk_start  (brk_start),
    .brk_end    (brk_end),
    .cmp_match  (cmp_match),
    .cmp_en     (cmp_en),
    .fr_vld     (fr_vld),
    .fifo_level (fifo_level)
);

// File: tb/test_uart_rx_brk.sv
`timescale 1ns/1ps
module test_uart_rx_brk;
    import uart_rx_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       samp_en;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_par_val = 1'b0;
    logic       cmp_en = 1'b0;
    logic [7:0] cmp_val = 8'h00;
    logic       pop = 1'b0;
    logic       rd_valid, rd_perr, rd_ferr, rd_ovr, rd_brk;
    logic [7:0] rd_data;
    logic       brk_start, brk_end, cmp_match;

    int checks = 0;
    int errors = 0;
    int n_bs = 0, n_be = 0, n_cm = 0;
    int cyc = 0;
    int t_start = 0;
    int t_rv = 0;
    logic rv_prev = 1'b0;
    logic [1:0] div = 2'd0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        div <= rst ? 2'd0 : div + 2'd1;
    end
    assign samp_en = (div == 2'd3);

    always @(negedge clk) begin
        if (brk_start) n_bs++;
        if (brk_end)   n_be++;
        if (cmp_match) n_cm++;
        if (rd_valid && !rv_prev) t_rv = cyc;
        rv_prev = rd_valid;
    end

    uart_rx_brk i_uart_rx_brk (
        .clk(clk), .rst(rst), .samp_en(samp_en), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_val(cfg_par_val),
        .cmp_en(cmp_en), .cmp_val(cmp_val), .pop(pop),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_ovr(rd_ovr), .rd_brk(rd_brk),
        .brk_start(brk_start), .brk_end(brk_end), .cmp_match(cmp_match)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_bit();
        repeat (64) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input logic use_par,
                              input logic pb, input logic stp, input int idle);
        @(negedge clk);
        while (div != 2'd0) @(negedge clk);
        t_start = cyc;
        rxd = 1'b0; hold_bit();
        for (int i = 0; i < nb; i++) begin rxd = d[i]; hold_bit(); end
        if (use_par) begin rxd = pb; hold_bit(); end
        rxd = stp; hold_bit();
        rxd = 1'b1;
        repeat (idle) hold_bit();
    endtask

    function automatic logic exp_perr(input logic [7:0] d, input logic [1:0] m,
                                      input logic pv, input logic pb);
        case (m)
            2'd1: return (^d) ^ pb;
            2'd2: return ~((^d) ^ pb);
            2'd3: return pb != pv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic rx_word_t mk(input logic [7:0] d, input logic pe, input logic fe,
                                    input logic ov, input logic bk);
        rx_word_t w;
        w.data = d; w.perr = pe; w.ferr = fe; w.ovr = ov; w.brk = bk;
        return w;
    endfunction

    task automatic pop_expect(input rx_word_t e, input string req);
        rx_word_t a;
        @(negedge clk);
        a = {rd_brk, rd_ovr, rd_ferr, rd_perr, rd_data};
        chk(rd_valid && (a == e), req, {19'd0, rd_valid, a}, {19'd0, 1'b1, e});
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        chk(!rd_valid, req, 32'(rd_valid), 32'd0);
    endtask

    initial begin
        int seed_dummy;
        int lat;
        int bs0, cm0;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!rd_valid && !brk_start && !brk_end && !cmp_match, "R11 reset",
            {28'd0, rd_valid, brk_start, brk_end, cmp_match}, 32'd0);

        // R7 pop on empty has no effect
        pop = 1'b1; @(negedge clk); pop = 1'b0;
        expect_empty("R7 pop on empty");

        // R1 false start: 4 strobes low
        rxd = 1'b0; repeat (16) @(negedge clk); rxd = 1'b1;
        repeat (20) hold_bit();
        expect_empty("R1 false start");

        // R2 R3 R10 constrained random characters
        for (int n = 0; n < 30; n++) begin
            logic [7:0] d;
            int nb;
            logic pb, stp, up;
            cfg_len     = 2'($urandom_range(0, 3));
            cfg_par     = 2'($urandom_range(0, 3));
            cfg_par_val = 1'($urandom_range(0, 1));
            nb  = 5 + int'(cfg_len);
            d   = 8'($urandom_range(0, 255)) & 8'((1 << nb) - 1);
            up  = (cfg_par != 2'd0);
            stp = ($urandom_range(0, 7) != 0);
            if (!stp) d[0] = 1'b1;
            pb  = 1'($urandom_range(0, 1));
            cmp_en  = 1'($urandom_range(0, 1));
            cmp_val = ($urandom_range(0, 1) != 0) ? d : (d ^ 8'h01);
            cm0 = n_cm;
            send_frame(d, nb, up, pb, stp, 1);
            pop_expect(mk(d, up ? exp_perr(d, cfg_par, cfg_par_val, pb) : 1'b0, !stp, 1'b0, 1'b0),
                       "R2 R3 R4 random char");
            chk((n_cm - cm0) == int'(cmp_en && (cmp_val == d)), "R10 compare",
                32'(n_cm - cm0), 32'(cmp_en && (cmp_val == d)));
        end
        cmp_en = 1'b0;

        // R3 directed: odd parity correct and fixed parity wrong
        cfg_len = 2'd3; cfg_par = 2'd2;
        send_frame(8'h07, 8, 1'b1, 1'b0, 1'b1, 1);
        pop_expect(mk(8'h07, 1'b0, 1'b0, 1'b0, 1'b0), "R3 odd parity good");
        cfg_par = 2'd3; cfg_par_val = 1'b1;
        send_frame(8'h5A, 8, 1'b1, 1'b0, 1'b1, 1);
        pop_expect(mk(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0), "R3 fixed parity wrong");

        // R4 framing error then half-bit resume
        cfg_par = 2'd0;
        send_frame(8'h55, 8, 1'b0, 1'b0, 1'b0, 2);
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1, 1);
        pop_expect(mk(8'h55, 1'b0, 1'b1, 1'b0, 1'b0), "R4 framing char");
        pop_expect(mk(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0), "R4 next char");
        expect_empty("R4 no spurious char");

        // R5 R6 R10 break
        cmp_en = 1'b1; cmp_val = 8'h00;
        bs0 = n_bs; cm0 = n_cm;
        @(negedge clk); rxd = 1'b0;
        repeat (30) hold_bit();
        chk(n_bs - bs0 == 1, "R5 one break start", 32'(n_bs - bs0), 32'd1);
        chk(n_be == 0, "R6 no end while low", 32'(n_be), 32'd0);
        rxd = 1'b1;
        repeat (2) hold_bit();
        chk(n_be == 1, "R6 break end", 32'(n_be), 32'd1);
        chk(n_cm == cm0, "R10 no match on break", 32'(n_cm - cm0), 32'd0);
        pop_expect(mk(8'h00, 1'b0, 1'b1, 1'b0, 1'b1), "R5 break entry");
        expect_empty("R5 single break entry");
        cmp_en = 1'b0;

        // R8 overrun
        for (int k = 0; k < 5; k++) send_frame(8'hA0 + 8'(k), 8, 1'b0, 1'b0, 1'b1, 1);
        for (int k = 0; k < 4; k++) pop_expect(mk(8'hA0 + 8'(k), 1'b0, 1'b0, 1'b0, 1'b0), "R8 kept chars");
        expect_empty("R8 dropped char");
        send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1, 1);
        pop_expect(mk(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0), "R8 overrun flag");

        // R9 push and pop in the same cycle on a full FIFO
        send_frame(8'hB0, 8, 1'b0, 1'b0, 1'b1, 1);
        lat = t_rv - t_start;
        for (int k = 1; k < 4; k++) send_frame(8'hB0 + 8'(k), 8, 1'b0, 1'b0, 1'b1, 1);
        fork
            send_frame(8'hB4, 8, 1'b0, 1'b0, 1'b1, 1);
            begin
                @(negedge clk);
                while (cyc != t_start + lat - 1) @(negedge clk);
                chk(rd_valid && rd_data == 8'hB0, "R9 head before pop", 32'(rd_data), 32'hB0);
                pop = 1'b1;
                @(negedge clk);
                pop = 1'b0;
            end
        join
        for (int k = 1; k < 5; k++) pop_expect(mk(8'hB0 + 8'(k), 1'b0, 1'b0, 1'b0, 1'b0), "R9 simultaneous");
        expect_empty("R9 drained");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule